// File: doc/BRIEF.md
# Double-Buffered Display Latch Refresh

This block holds the data that drives a PWM display engine in two stages so that new data can be written at any moment without disturbing a display period that is already running. A latch strobe, together with a select input, captures the current shift-register word into one of two first-stage registers: the grayscale word or the control word. The control word carries dot-correction and brightness data plus a set of mode bits. The second stage feeds the PWM engine. It normally takes the first-stage contents only when the end-of-period pulse arrives.

Three conditions override the wait for the end of the period. While the blank mode bit is set, or in the write that sets or clears it, the second stage takes the first-stage contents at once. A grayscale write made while the timing-reset mode bit is set also moves both stages at once, and it raises a one-cycle restart pulse so that the outside period counter starts from zero. The mode bits are never buffered. They act from the cycle after they are written.

A small controller tracks the relation between the two stages in three states:
- `ST_BLANKED`: blank is set, and the second stage follows the first.
- `ST_SYNCED`: both stages hold the same data.
- `ST_PENDING`: the first stage holds data that has not yet been promoted.

The controller moves between these states as follows:
- `ST_BLANKED` goes to `ST_SYNCED` on a write that clears blank.
- Any state goes to `ST_BLANKED` when blank becomes or stays set.
- `ST_SYNCED` goes to `ST_PENDING` on an unpromoted write.
- `ST_PENDING` goes to `ST_SYNCED` on any promotion: end of period, blank, or a timing-reset grayscale write.
- Otherwise the state holds.

Top module: `dbuf_refresh`

## Requirements
- R1: After reset, `gs_act` and `dc_act` are zero, `restart` is 0, and `mode_now` has only the blank bit (bit `BLANK_BIT`, default 0) set.
- R2: The select input `lat_sel` chooses which first-stage register a strobe writes. When `lat_sel`=0, the strobe loads `shift_word[GS_W-1:0]` into the first-stage grayscale register. When `lat_sel`=1, it loads `shift_word[MODE_W-1:0]` into the mode bits and `shift_word[MODE_W+DC_W-1:MODE_W]` into the first-stage dot-correction register. The register that was not selected keeps its value.
- R3: While blank is 0 before and after a write, the write leaves `gs_act` and `dc_act` unchanged until a promotion. This holds for a grayscale write only when the timing-reset bit (bit `TMG_BIT`, default 1) is 0.
- R4: When `period_end` is 1 at a clock edge, `gs_act` and `dc_act` show the first-stage contents right after that edge.
- R5: When a strobe and `period_end` occur in the same cycle, the word latched in that cycle is the one promoted.
- R6: A write made while blank is 1, or a write that sets or clears blank, reaches `gs_act`/`dc_act` right after its edge, together with the rest of the first stage.
- R7: A grayscale write made while the timing-reset bit is 1 puts the word on `gs_act`, promotes the first-stage dot-correction data to `dc_act` at the same edge, and drives `restart` high for the following cycle.
- R8: `mode_now` shows the written mode bits right after the control strobe's edge.
- R9: `restart` is 0 in any cycle that does not follow a grayscale write made with the timing-reset bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_word | input | SH_W | Word presented by the shift register |
| lat_stb | input | 1 | Latch strobe, one cycle per write |
| lat_sel | input | 1 | 0 = grayscale write, 1 = control write |
| period_end | input | 1 | End-of-display-period pulse |
| gs_act | output | GS_W | Second-stage grayscale data to the PWM engine |
| dc_act | output | DC_W | Second-stage dot-correction/brightness data |
| mode_now | output | MODE_W | Mode bits, effective immediately |
| restart | output | 1 | One-cycle period-counter restart request |

## Verification
The bench builds the block with `GS_W`=16, `DC_W`=12 and `MODE_W`=4, so one 16-bit shift word covers both the grayscale word and the full control word. With these widths, each hand-picked pattern shows at a glance whether a control write reached the grayscale path. The bench drives every promotion cause:
- end of period alone, and end of period coinciding with a strobe;
- blank being set, held and cleared;
- a timing-reset grayscale write.

In each case a behavioural reference model is compared with the block's outputs on every cycle.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    typedef enum logic [1:0] {
        ST_BLANKED = 2'd0,
        ST_SYNCED  = 2'd1,
        ST_PENDING = 2'd2
    } dbr_state_e;

    localparam logic SEL_GS  = 1'b0;
    localparam logic SEL_CTL = 1'b1;
endpackage

// File: rtl/dbr_stage1.sv
module dbr_stage1 #(
    parameter int GS_W      = 48,
    parameter int DC_W      = 24,
    parameter int MODE_W    = 8,
    parameter int SH_W      = 48,
    parameter int BLANK_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SH_W-1:0]   word,
    input  logic              gs_stb,
    input  logic              ctl_stb,
    output logic [GS_W-1:0]   gs1_q,
    output logic [DC_W-1:0]   dc1_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [GS_W-1:0]   gs1_d,
    output logic [DC_W-1:0]   dc1_d,
    output logic [MODE_W-1:0] mode_d
);
    localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(1) << BLANK_BIT;

    always_comb begin
        gs1_d  = gs_stb  ? word[GS_W-1:0]     : gs1_q;
        dc1_d  = ctl_stb ? word[MODE_W +: DC_W] : dc1_q;
        mode_d = ctl_stb ? word[MODE_W-1:0]   : mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs1_q  <= '0;
            dc1_q  <= '0;
            mode_q <= MODE_RST;
        end else begin
            gs1_q  <= gs1_d;
            dc1_q  <= dc1_d;
            mode_q <= mode_d;
        end
    end

    assert_mode_immediate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stb |=> mode_q == $past(word[MODE_W-1:0]));

    assert_gs_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_stb && !ctl_stb) |=> ($stable(dc1_q) && $stable(mode_q)));
endmodule

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
    import dbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gs_stb,
    input  logic       ctl_stb,
    input  logic       period_end,
    input  logic       blank_cur,
    input  logic       blank_nxt,
    input  logic       tmg_cur,
    output logic       promote,
    output logic       restart_o,
    output dbr_state_e state_o
);
    dbr_state_e state_q, state_d;
    logic       any_stb;
    logic       tmg_hit;

    assign any_stb = gs_stb | ctl_stb;
    assign tmg_hit = gs_stb & tmg_cur;

    always_comb begin
        promote = blank_cur | blank_nxt | period_end | tmg_hit;
        state_d = state_q;
        unique case (state_q)
            ST_BLANKED: begin
                if (!blank_nxt) state_d = ST_SYNCED;
            end
            ST_SYNCED: begin
                if (blank_nxt)     state_d = ST_BLANKED;
                else if (promote)  state_d = ST_SYNCED;
                else if (any_stb)  state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (blank_nxt)     state_d = ST_BLANKED;
                else if (promote)  state_d = ST_SYNCED;
            end
            default: state_d = ST_BLANKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANKED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) restart_o <= 1'b0;
        else        restart_o <= tmg_hit;
    end

    assign state_o = state_q;

    assert_restart_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(gs_stb && tmg_cur));

    assert_tmg_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_stb && tmg_cur) |=> restart_o);
endmodule

// File: rtl/dbr_stage2.sv
module dbr_stage2 #(
    parameter int GS_W = 48,
    parameter int DC_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            promote,
    input  logic [GS_W-1:0] gs1_d,
    input  logic [DC_W-1:0] dc1_d,
    output logic [GS_W-1:0] gs2_q,
    output logic [DC_W-1:0] dc2_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs2_q <= '0;
            dc2_q <= '0;
        end else if (promote) begin
            gs2_q <= gs1_d;
            dc2_q <= dc1_d;
        end
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !promote |=> ($stable(gs2_q) && $stable(dc2_q)));

    assert_promote_R4: assert property (@(posedge clk) disable iff (!rst_n)
        promote |=> (gs2_q == $past(gs1_d) && dc2_q == $past(dc1_d)));
endmodule

// File: rtl/dbuf_refresh.sv
module dbuf_refresh
    import dbr_pkg::*;
#(
    parameter int GS_W      = 48,
    parameter int DC_W      = 24,
    parameter int MODE_W    = 8,
    parameter int BLANK_BIT = 0,
    parameter int TMG_BIT   = 1,
    parameter int SH_W      = (GS_W > DC_W + MODE_W) ? GS_W : DC_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SH_W-1:0]   shift_word,
    input  logic              lat_stb,
    input  logic              lat_sel,
    input  logic              period_end,
    output logic [GS_W-1:0]   gs_act,
    output logic [DC_W-1:0]   dc_act,
    output logic [MODE_W-1:0] mode_now,
    output logic              restart
);
    logic              gs_stb, ctl_stb, promote;
    logic [GS_W-1:0]   gs1_q, gs1_d;
    logic [DC_W-1:0]   dc1_q, dc1_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    dbr_state_e        state;

    assign gs_stb  = lat_stb & (lat_sel == SEL_GS);
    assign ctl_stb = lat_stb & (lat_sel == SEL_CTL);

    dbr_stage1 #(
        .GS_W(GS_W), .DC_W(DC_W), .MODE_W(MODE_W), .SH_W(SH_W), .BLANK_BIT(BLANK_BIT)
    ) u_stage1 (
        .clk(clk), .rst_n(rst_n), .word(shift_word),
        .gs_stb(gs_stb), .ctl_stb(ctl_stb),
        .gs1_q(gs1_q), .dc1_q(dc1_q), .mode_q(mode_q),
        .gs1_d(gs1_d), .dc1_d(dc1_d), .mode_d(mode_d)
    );

    dbr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .gs_stb(gs_stb), .ctl_stb(ctl_stb), .period_end(period_end),
        .blank_cur(mode_q[BLANK_BIT]), .blank_nxt(mode_d[BLANK_BIT]),
        .tmg_cur(mode_q[TMG_BIT]),
        .promote(promote), .restart_o(restart), .state_o(state)
    );

    dbr_stage2 #(.GS_W(GS_W), .DC_W(DC_W)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .promote(promote),
        .gs1_d(gs1_d), .dc1_d(dc1_d),
        .gs2_q(gs_act), .dc2_q(dc_act)
    );

    assign mode_now = mode_q;

    assert_blank_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[BLANK_BIT] |-> (gs_act == gs1_q && dc_act == dc1_q));

    assert_synced_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNCED) |-> (gs_act == gs1_q && dc_act == dc1_q));

    assert_state_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANKED) == mode_q[BLANK_BIT]);
endmodule

// File: tb/sim_dbuf_refresh.sv
`timescale 1ns/1ps
module sim_dbuf_refresh;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] shift_word = '0;
    logic        lat_stb = 1'b0;
    logic        lat_sel = 1'b0;
    logic        period_end = 1'b0;
    logic [15:0] gs_act;
    logic [11:0] dc_act;
    logic [3:0]  mode_now;
    logic        restart;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_en = 1'b0;

    logic [15:0] m_gs1, m_gs2;
    logic [11:0] m_dc1, m_dc2;
    logic [3:0]  m_mode;
    logic        m_restart;

    always #2 clk = ~clk;

    dbuf_refresh #(.GS_W(16), .DC_W(12), .MODE_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_word(shift_word),
        .lat_stb(lat_stb), .lat_sel(lat_sel), .period_end(period_end),
        .gs_act(gs_act), .dc_act(dc_act), .mode_now(mode_now), .restart(restart)
    );

    // Behavioural reference: blank is mode bit 0, timing reset is mode bit 1.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_gs1 = 0; m_gs2 = 0; m_dc1 = 0; m_dc2 = 0; m_mode = 4'b0001; m_restart = 0;
        end else begin
            bit blank_was, tmg_was, gw, cw, take;
            logic [15:0] g1; logic [11:0] d1; logic [3:0] md;
            blank_was = m_mode[0];
            tmg_was   = m_mode[1];
            gw = lat_stb && !lat_sel;
            cw = lat_stb && lat_sel;
            g1 = gw ? shift_word : m_gs1;
            d1 = cw ? shift_word[15:4] : m_dc1;
            md = cw ? shift_word[3:0] : m_mode;
            take = blank_was || md[0] || period_end || (gw && tmg_was);
            if (take) begin m_gs2 = g1; m_dc2 = d1; end
            m_gs1 = g1; m_dc1 = d1; m_mode = md;
            m_restart = gw && tmg_was;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, 32'(gs_act), 32'(m_gs2));
            chk(cur_req, 32'(dc_act), 32'(m_dc2));
            chk(cur_req, 32'(mode_now), 32'(m_mode));
            chk(cur_req, 32'(restart), 32'(m_restart));
        end
    end

    task automatic strobe(input logic sel, input logic [15:0] w, input logic pe);
        @(negedge clk);
        lat_stb = 1'b1; lat_sel = sel; shift_word = w; period_end = pe;
        @(negedge clk);
        lat_stb = 1'b0; period_end = 1'b0;
    endtask

    task automatic end_period();
        @(negedge clk);
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 32'(gs_act), 0);
        chk("R1", 32'(dc_act), 0);
        chk("R1", 32'(mode_now), 32'h1);
        chk("R1", 32'(restart), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R6";
        strobe(1'b0, 16'h1234, 1'b0);
        chk("R6", 32'(gs_act), 32'h1234);
        strobe(1'b1, {12'hABC, 4'b0000}, 1'b0);
        chk("R6", 32'(dc_act), 32'hABC);
        chk("R8", 32'(mode_now), 0);

        cur_req = "R3";
        strobe(1'b0, 16'h5555, 1'b0);
        chk("R3", 32'(gs_act), 32'h1234);
        chk("R9", 32'(restart), 0);
        strobe(1'b0, 16'h6666, 1'b0);
        strobe(1'b1, {12'h123, 4'b0000}, 1'b0);
        chk("R3", 32'(dc_act), 32'hABC);
        chk("R3", 32'(gs_act), 32'h1234);
        repeat (3) @(negedge clk);

        cur_req = "R4";
        end_period();
        chk("R4", 32'(gs_act), 32'h6666);
        chk("R2", 32'(dc_act), 32'h123);

        cur_req = "R5";
        strobe(1'b0, 16'h7777, 1'b1);
        chk("R5", 32'(gs_act), 32'h7777);
        strobe(1'b1, {12'h0F0, 4'b0000}, 1'b0);
        chk("R3", 32'(dc_act), 32'h123);

        cur_req = "R6";
        strobe(1'b1, {12'h0F1, 4'b0001}, 1'b0);
        chk("R6", 32'(dc_act), 32'h0F1);
        chk("R8", 32'(mode_now), 32'h1);
        strobe(1'b0, 16'h8888, 1'b0);
        chk("R6", 32'(gs_act), 32'h8888);
        strobe(1'b1, {12'h222, 4'b0010}, 1'b0);
        chk("R6", 32'(dc_act), 32'h222);
        chk("R8", 32'(mode_now), 32'h2);

        cur_req = "R7";
        strobe(1'b1, {12'h333, 4'b0010}, 1'b0);
        chk("R3", 32'(dc_act), 32'h222);
        strobe(1'b0, 16'h9999, 1'b0);
        chk("R7", 32'(gs_act), 32'h9999);
        chk("R7", 32'(dc_act), 32'h333);
        chk("R7", 32'(restart), 1);
        @(negedge clk);
        chk("R9", 32'(restart), 0);

        cur_req = "R9";
        strobe(1'b1, {12'h444, 4'b0000}, 1'b0);
        strobe(1'b0, 16'hAAAA, 1'b0);
        chk("R9", 32'(restart), 0);
        chk("R3", 32'(gs_act), 32'h9999);
        end_period();
        chk("R4", 32'(gs_act), 32'hAAAA);
        chk("R4", 32'(dc_act), 32'h444);
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule